// File: doc/BRIEF.md
# FPGA Configuration Load Controller

This block loads a configuration image into one of two downstream FPGAs. It reads the image one byte at a time from a local buffer and writes each byte to the configuration port of the chosen FPGA. It also runs the pin handshake that the FPGA needs around the transfer. A one-cycle `start` pulse launches a load. The pulse carries a target select, a buffer start address and a byte count, and all three are captured when the load is accepted.

For an accepted load the block does the following, in order:
1. It raises the target's enable line, if that target has one, and releases the target's INIT hold.
2. It holds the target's active-low PROG pin low for a programmable number of cycles.
3. It waits for INIT to go high, with a timeout.
4. It streams the image bytes to the target's configuration address.
5. It waits for DONE to go high, with a timeout.

The load then ends with a one-cycle `done_valid` pulse that carries a 2-bit result code. The enable line is dropped in that same cycle, whether the load passed or failed. If the selected target has no configuration port, the block reports a failure at once and never touches any pin.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset `busy` and `done_valid` are 0, both `prog_n` bits are 1, both `enable` bits are 0, and both `init_hold` bits are 1, so INIT is held low and automatic configuration is deferred.
- R2: When a start is accepted for a target that has a port, `enable` of that target rises, if it has an enable line, and its `init_hold` bit clears and stays clear. Both happen at least one cycle before its `prog_n` goes low.
- R3: `prog_n` of the selected target is low for exactly PROG_LOW_CYC consecutive cycles per load. The other target's `prog_n` stays high.
- R4: INIT is polled once per cycle, starting on the first cycle after `prog_n` rises. If INIT is seen on poll number INIT_POLLS, the load proceeds. If INIT is still low after INIT_POLLS polls, the result is 2 (no INIT), no byte is written, and `done_valid` appears exactly INIT_POLLS cycles after `prog_n` rises.
- R5: Exactly `byte_count` bytes are read from the buffer, starting at `start_addr` and going up one address at a time, wrapping modulo the buffer size. Each byte is written unchanged to the selected target's fixed configuration base address. A count of 0 writes nothing.
- R6: DONE is polled once per cycle, starting two cycles after the cycle of the last byte write. If DONE is still low after DONE_POLLS polls, the result is 3 (no DONE). A DONE seen on the last allowed poll still counts as success.
- R7: A load that sees DONE high reports result 0.
- R8: A start for a target without a configuration port reports result 1 on the next cycle. It leaves `busy` low, and it leaves every `prog_n`, `enable` and `init_hold` pin unchanged.
- R9: `enable` falls in the same cycle as the `done_valid` pulse, whatever the result.
- R10: `busy` is high from the cycle after an accepted start until the result. `done_valid` is a single-cycle pulse, presented with `busy` low.
- R11: A `start` pulse received while `busy` is high is ignored. It produces no extra result and does not change the load in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle load request |
| tgt_sel | input | 1 | Target select: 0 main, 1 mezzanine |
| start_addr | input | BUF_AW | First buffer address of the image |
| byte_count | input | LEN_W | Number of image bytes |
| buf_rd_en | output | 1 | Buffer read strobe |
| buf_rd_addr | output | BUF_AW | Buffer read address |
| buf_rd_data | input | 8 | Buffer read data, valid one cycle after the strobe |
| cfg_wr_en | output | 1 | Configuration port write strobe |
| cfg_wr_addr | output | CFG_AW | Configuration port address of the target |
| cfg_wr_data | output | 8 | Configuration byte |
| prog_n | output | 2 | Active-low PROG, one per target |
| init_hold | output | 2 | 1 = drive the target's INIT low |
| init_in | input | 2 | INIT level, one per target |
| done_in | input | 2 | DONE level, one per target |
| enable | output | 2 | Target enable, high only during a load |
| busy | output | 1 | Load in progress |
| done_valid | output | 1 | One-cycle result strobe |
| result | output | 2 | 0 ok, 1 no port, 2 no INIT, 3 no DONE |

## Verification
The bench sweeps byte counts from 0 to 16, start addresses that include a wrap past the top of the buffer, and several INIT and DONE response delays. This shows that the write order, data, address and count do not depend on handshake timing. INIT and DONE delays are placed exactly on the last allowed poll and one cycle past it. That separates an off-by-one in either timeout from a correct one, and the measured wait lengths confirm each window. Separate runs cover a target with no port, a permanently low INIT, a permanently low DONE, and a start pulse during a load. These show that each failure path produces its own code, drops the enable line, and leaves the pins of the idle target alone.

// File: rtl/fcl_pkg.sv
// Shared types for the configuration load controller.
// Assumes exactly two targets; the result encoding is visible at the top ports.
package fcl_pkg;
    localparam int NT    = 2;
    localparam int SEL_W = 1;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_NO_PORT = 2'd1,
        RES_NO_INIT = 2'd2,
        RES_NO_DONE = 2'd3
    } res_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARM    = 3'd1,
        ST_PROG   = 3'd2,
        ST_WINIT  = 3'd3,
        ST_STREAM = 3'd4,
        ST_WDONE  = 3'd5
    } state_t;
endpackage

// File: rtl/fcl_poll_ctr.sv
// Shared up-counter that times the PROG pulse and both poll windows.
// Assumes the controller clears it before each window and never lets it run past its width.
module fcl_poll_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // count up on inc, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    AST_CTR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && !clr && (&cnt))); // R4
endmodule

// File: rtl/fcl_byte_stream.sv
// Moves byte_count bytes from the buffer to the configuration write strobe.
// Assumes buffer read data arrives one cycle after the read strobe.
module fcl_byte_stream #(
    parameter int AW = 8,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] first_addr,
    input  logic [LW-1:0] count,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic          fin
);
    logic          active;
    logic [AW-1:0] ptr;
    logic [LW-1:0] remain;
    logic          pend;

    assign rd_en   = active && (remain != '0);
    assign rd_addr = ptr;
    assign wr_en   = pend;
    assign fin     = active && (remain == '0) && !pend;

    // walk the address range, one read per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            ptr    <= '0;
            remain <= '0;
            pend   <= 1'b0;
        end else begin
            pend <= rd_en;
            if (go) begin
                active <= 1'b1;
                ptr    <= first_addr;
                remain <= count;
            end else if (fin) begin
                active <= 1'b0;
            end else if (rd_en) begin
                ptr    <= ptr + 1'b1;
                remain <= remain - 1'b1;
            end
        end
    end

    AST_RD_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (wr_en && active)); // R5
endmodule

// File: rtl/fcl_pin_route.sv
// Routes the shared sequencing signals onto the pins of the selected target.
// Holds each INIT low from reset until that target's first accepted load.
module fcl_pin_route
    import fcl_pkg::*;
#(
    parameter int          CFG_AW     = 16,
    parameter logic [NT-1:0] HAS_EN   = '1,
    parameter logic [NT*CFG_AW-1:0] BASES = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel_q,
    input  logic [SEL_W-1:0]  rel_sel,
    input  logic              rel_stb,
    input  logic              en_on,
    input  logic              prog_low,
    input  logic [NT-1:0]     init_in,
    input  logic [NT-1:0]     done_in,
    output logic [NT-1:0]     prog_n,
    output logic [NT-1:0]     enable,
    output logic [NT-1:0]     init_hold,
    output logic              init_seen,
    output logic              done_seen,
    output logic [CFG_AW-1:0] wr_base
);
    logic [CFG_AW-1:0] base_arr [NT];

    for (genvar t = 0; t < NT; t++) begin : g_tgt
        logic hit;
        assign hit         = (sel_q == SEL_W'(t));
        assign base_arr[t] = BASES[t*CFG_AW +: CFG_AW];
        assign prog_n[t]   = !(prog_low && hit);
        assign enable[t]   = en_on && hit && HAS_EN[t];

        // INIT hold is dropped once, at the first load of this target
        always_ff @(posedge clk) begin
            if (!rst_n)                                   init_hold[t] <= 1'b1;
            else if (rel_stb && (rel_sel == SEL_W'(t)))   init_hold[t] <= 1'b0;
        end

        AST_INIT_STAYS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            !init_hold[t] |=> !init_hold[t]); // R2
    end

    assign init_seen = init_in[sel_q];
    assign done_seen = done_in[sel_q];
    assign wr_base   = base_arr[sel_q];

    AST_PROG_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~prog_n)); // R3
endmodule

// File: rtl/fcl_load_fsm.sv
// Sequencer: enable and release, PROG pulse, INIT wait, stream, DONE wait, result.
// Assumes INIT and DONE are already synchronous to clk.
module fcl_load_fsm
    import fcl_pkg::*;
#(
    parameter int            CTR_W        = 8,
    parameter int            PROG_LOW_CYC = 20,
    parameter int            INIT_POLLS   = 100,
    parameter int            DONE_POLLS   = 100,
    parameter logic [NT-1:0] HAS_PORT     = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SEL_W-1:0] tgt_sel,
    input  logic             init_seen,
    input  logic             done_seen,
    input  logic             strm_fin,
    input  logic [CTR_W-1:0] cnt,
    output logic             ctr_clr,
    output logic             ctr_inc,
    output logic             rel_stb,
    output logic             strm_go,
    output logic             accept,
    output logic [SEL_W-1:0] sel_q,
    output logic             en_on,
    output logic             prog_low,
    output logic             busy,
    output logic             done_valid,
    output res_t             result
);
    localparam logic [CTR_W-1:0] PROG_LAST = CTR_W'(PROG_LOW_CYC - 1);
    localparam logic [CTR_W-1:0] INIT_LAST = CTR_W'(INIT_POLLS - 1);
    localparam logic [CTR_W-1:0] DONE_LAST = CTR_W'(DONE_POLLS - 1);

    state_t state;
    logic   prog_end;

    assign busy     = (state != ST_IDLE);
    assign accept   = (state == ST_IDLE) && start;
    assign rel_stb  = accept && HAS_PORT[tgt_sel];
    assign strm_go  = (state == ST_WINIT) && init_seen;
    assign prog_end = (state == ST_PROG) && (cnt == PROG_LAST);

    // counter control: clear at each window start, count while timing
    always_comb begin
        ctr_clr = (state == ST_IDLE) || (state == ST_ARM) ||
                  (state == ST_STREAM) || prog_end;
        ctr_inc = (state == ST_PROG) || (state == ST_WINIT) || (state == ST_WDONE);
    end

    // main sequence and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sel_q      <= '0;
            en_on      <= 1'b0;
            prog_low   <= 1'b0;
            done_valid <= 1'b0;
            result     <= RES_OK;
        end else begin
            done_valid <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    sel_q <= tgt_sel;
                    if (!HAS_PORT[tgt_sel]) begin
                        done_valid <= 1'b1;
                        result     <= RES_NO_PORT;
                    end else begin
                        en_on <= 1'b1;
                        state <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    prog_low <= 1'b1;
                    state    <= ST_PROG;
                end
                ST_PROG: if (prog_end) begin
                    prog_low <= 1'b0;
                    state    <= ST_WINIT;
                end
                ST_WINIT: if (init_seen) begin
                    state <= ST_STREAM;
                end else if (cnt == INIT_LAST) begin
                    state      <= ST_IDLE;
                    en_on      <= 1'b0;
                    done_valid <= 1'b1;
                    result     <= RES_NO_INIT;
                end
                ST_STREAM: if (strm_fin) begin
                    state <= ST_WDONE;
                end
                ST_WDONE: if (done_seen || (cnt == DONE_LAST)) begin
                    state      <= ST_IDLE;
                    en_on      <= 1'b0;
                    done_valid <= 1'b1;
                    result     <= done_seen ? RES_OK : RES_NO_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(sel_q)); // R11
    AST_PROG_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_low) |-> en_on); // R2
endmodule

// File: rtl/fpga_cfg_loader.sv
// Top of the configuration load controller: sequencer, byte streamer,
// poll counter and per-target pin routing. All inputs are synchronous to clk.
module fpga_cfg_loader
    import fcl_pkg::*;
#(
    parameter int              BUF_AW       = 8,
    parameter int              LEN_W        = 16,
    parameter int              CFG_AW       = 16,
    parameter int              PROG_LOW_CYC = 20,
    parameter int              INIT_POLLS   = 10_000_000,
    parameter int              DONE_POLLS   = 100_000_000,
    parameter logic [1:0]      TGT_HAS_PORT = 2'b11,
    parameter logic [1:0]      TGT_HAS_EN   = 2'b11,
    parameter logic [CFG_AW-1:0] MAIN_BASE  = CFG_AW'(16'h4000),
    parameter logic [CFG_AW-1:0] MEZZ_BASE  = CFG_AW'(16'h8000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tgt_sel,
    input  logic [BUF_AW-1:0] start_addr,
    input  logic [LEN_W-1:0]  byte_count,
    output logic              buf_rd_en,
    output logic [BUF_AW-1:0] buf_rd_addr,
    input  logic [7:0]        buf_rd_data,
    output logic              cfg_wr_en,
    output logic [CFG_AW-1:0] cfg_wr_addr,
    output logic [7:0]        cfg_wr_data,
    output logic [1:0]        prog_n,
    output logic [1:0]        init_hold,
    input  logic [1:0]        init_in,
    input  logic [1:0]        done_in,
    output logic [1:0]        enable,
    output logic              busy,
    output logic              done_valid,
    output logic [1:0]        result
);
    localparam int MAX_A  = (INIT_POLLS > DONE_POLLS) ? INIT_POLLS : DONE_POLLS;
    localparam int MAX_W  = (MAX_A > PROG_LOW_CYC) ? MAX_A : PROG_LOW_CYC;
    localparam int CTR_W  = $clog2(MAX_W + 1);

    logic [CTR_W-1:0]  cnt;
    logic              ctr_clr, ctr_inc, rel_stb, strm_go, strm_fin, accept;
    logic              en_on, prog_low, init_seen, done_seen;
    logic [SEL_W-1:0]  sel_q;
    logic [BUF_AW-1:0] addr_q;
    logic [LEN_W-1:0]  count_q;
    res_t              res_q;

    // capture image location on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            count_q <= '0;
        end else if (accept) begin
            addr_q  <= start_addr;
            count_q <= byte_count;
        end
    end

    fcl_poll_ctr #(.W(CTR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .inc(ctr_inc), .cnt(cnt)
    );

    fcl_load_fsm #(
        .CTR_W(CTR_W), .PROG_LOW_CYC(PROG_LOW_CYC), .INIT_POLLS(INIT_POLLS),
        .DONE_POLLS(DONE_POLLS), .HAS_PORT(TGT_HAS_PORT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_sel(tgt_sel),
        .init_seen(init_seen), .done_seen(done_seen), .strm_fin(strm_fin),
        .cnt(cnt), .ctr_clr(ctr_clr), .ctr_inc(ctr_inc), .rel_stb(rel_stb),
        .strm_go(strm_go), .accept(accept), .sel_q(sel_q), .en_on(en_on),
        .prog_low(prog_low), .busy(busy), .done_valid(done_valid), .result(res_q)
    );

    fcl_byte_stream #(.AW(BUF_AW), .LW(LEN_W)) u_stream (
        .clk(clk), .rst_n(rst_n), .go(strm_go), .first_addr(addr_q),
        .count(count_q), .rd_en(buf_rd_en), .rd_addr(buf_rd_addr),
        .wr_en(cfg_wr_en), .fin(strm_fin)
    );

    fcl_pin_route #(
        .CFG_AW(CFG_AW), .HAS_EN(TGT_HAS_EN), .BASES({MEZZ_BASE, MAIN_BASE})
    ) u_route (
        .clk(clk), .rst_n(rst_n), .sel_q(sel_q), .rel_sel(tgt_sel),
        .rel_stb(rel_stb), .en_on(en_on), .prog_low(prog_low),
        .init_in(init_in), .done_in(done_in), .prog_n(prog_n),
        .enable(enable), .init_hold(init_hold), .init_seen(init_seen),
        .done_seen(done_seen), .wr_base(cfg_wr_addr)
    );

    assign cfg_wr_data = buf_rd_data;
    assign result      = res_q;

    AST_PROG_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_n != 2'b11) |-> busy); // R3
    AST_EN_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable != 2'b00) |-> busy); // R9
    AST_WR_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |-> busy); // R5
    AST_DV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R10
    AST_DV_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (!busy && (enable == 2'b00))); // R9
    AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && TGT_HAS_PORT[tgt_sel]) |=> busy); // R10
    AST_NOPORT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !TGT_HAS_PORT[tgt_sel]) |=> (done_valid && !busy)); // R8
endmodule

// File: tb/fpga_cfg_loader_tb.sv
module fpga_cfg_loader_tb;
    localparam int PL = 5, IP = 12, DP = 16;
    localparam logic [15:0] BASE0 = 16'h4A00;

    logic clk = 0, rst_n = 0, start = 0, tgt_sel = 0;
    logic [7:0] start_addr = 0, byte_count = 0, buf_rd_data = 0;
    logic buf_rd_en, cfg_wr_en, busy, done_valid;
    logic [7:0] buf_rd_addr, cfg_wr_data;
    logic [15:0] cfg_wr_addr;
    logic [1:0] prog_n, init_hold, enable, result;
    logic [1:0] init_in = 0, done_in = 0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int ld_addr, ld_cnt, i_dly, d_dly;
    bit i_ok, d_ok;
    int wr_idx, prog_lo, dv_cnt, icnt, dcnt, t_rise, t_lw, t_dv, res_cap;
    bit rise_seen, en_at_fall, en_at_dv, prog1_lo, prog0_prev, data_bad;

    always #2.5 clk = ~clk;

    fpga_cfg_loader #(
        .BUF_AW(8), .LEN_W(8), .CFG_AW(16), .PROG_LOW_CYC(PL),
        .INIT_POLLS(IP), .DONE_POLLS(DP), .TGT_HAS_PORT(2'b01),
        .TGT_HAS_EN(2'b01), .MAIN_BASE(BASE0), .MEZZ_BASE(16'h8000)
    ) u_dut (.*);

    function automatic logic [7:0] img(input logic [7:0] a);
        return a * 8'd37 + 8'h5A;
    endfunction

    always @(posedge clk) if (buf_rd_en) buf_rd_data <= img(buf_rd_addr);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // target model and observation, sampled away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!prog_n[1]) prog1_lo = 1;
        if (!prog_n[0]) begin
            prog_lo++;
            if (prog0_prev) en_at_fall = enable[0];
            init_in[0] = 0; done_in[0] = 0; rise_seen = 0;
        end else if (!prog0_prev) begin
            t_rise = cyc; rise_seen = 1; icnt = 0;
        end
        prog0_prev = prog_n[0];
        if (rise_seen && i_ok) begin
            if (icnt >= i_dly) init_in[0] = 1;
            icnt++;
        end
        if (cfg_wr_en) begin
            if (cfg_wr_addr != BASE0 || cfg_wr_data != img(8'(ld_addr + wr_idx)))
                data_bad = 1;
            wr_idx++; t_lw = cyc;
        end
        if (d_ok && init_in[0] && wr_idx == ld_cnt) begin
            if (dcnt >= d_dly) done_in[0] = 1;
            dcnt++;
        end
        if (done_valid) begin
            dv_cnt++; t_dv = cyc; res_cap = result; en_at_dv = enable[0];
        end
    end

    task automatic run_load(input bit sel, input int a, input int c, input int id,
                            input bit iok, input int dd, input bit dok, input bit mid);
        int guard = 0;
        @(negedge clk); #1;
        ld_addr = a; ld_cnt = c; i_dly = id; i_ok = iok; d_dly = dd; d_ok = dok;
        wr_idx = 0; prog_lo = 0; dv_cnt = 0; dcnt = 0; t_dv = -1; t_lw = -1;
        en_at_fall = 0; en_at_dv = 1; prog1_lo = 0; data_bad = 0; res_cap = -1;
        start = 1; tgt_sel = sel; start_addr = 8'(a); byte_count = 8'(c);
        @(negedge clk); #1; start = 0;
        while (dv_cnt == 0 && guard < 3000) begin
            if (mid && guard == 8) begin start = 1; tgt_sel = 1; end
            if (mid && guard == 9) start = 0;
            @(negedge clk); #1; guard++;
        end
        chk(dv_cnt != 0, "watchdog R10", guard, 0);
        repeat (30) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy == 0 && done_valid == 0, "R1 busy/dv", busy, 0);
        chk(prog_n == 2'b11 && enable == 2'b00, "R1 prog/enable", {prog_n, enable}, 12);
        chk(init_hold == 2'b11, "R1 init_hold", init_hold, 3);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R8: portless target
        run_load(1, 5, 4, 0, 1, 0, 1, 0);
        chk(res_cap == 1 && t_dv >= 0, "R8 code", res_cap, 1);
        chk(wr_idx == 0 && prog_lo == 0 && !prog1_lo, "R8 no activity", wr_idx + prog_lo, 0);
        chk(init_hold == 2'b11, "R8 init held", init_hold, 3);

        // sweep of counts, addresses and handshake delays
        for (int ci = 0; ci < 6; ci++) begin
            for (int ii = 0; ii < 3; ii++) begin
                for (int di = 0; di < 2; di++) begin
                    int cnts[6] = '{0, 1, 2, 3, 7, 16};
                    int ids[3]  = '{0, 2, 5};
                    int a = (ci * 53 + ii * 91 + di * 120 + 250) % 256;
                    run_load(0, a, cnts[ci], ids[ii], 1, di * 3, 1, 0);
                    chk(res_cap == 0, "R7 success code", res_cap, 0);
                    chk(wr_idx == cnts[ci], "R5 byte count", wr_idx, cnts[ci]);
                    chk(!data_bad, "R5 data/address order", data_bad, 0);
                    chk(prog_lo == PL, "R3 PROG width", prog_lo, PL);
                    chk(!prog1_lo, "R3 other PROG idle", prog1_lo, 0);
                    chk(en_at_fall, "R2 enable before PROG", en_at_fall, 1);
                    chk(init_hold == 2'b10, "R2 INIT released", init_hold, 2);
                    chk(!en_at_dv && enable == 0, "R9 enable low at result", en_at_dv, 0);
                    chk(dv_cnt == 1 && !busy, "R10 single result", dv_cnt, 1);
                end
            end
        end

        // R4: INIT on last allowed poll, then one past it, then never
        run_load(0, 10, 3, IP - 1, 1, 0, 1, 0);
        chk(res_cap == 0 && wr_idx == 3, "R4 INIT last poll", res_cap, 0);
        run_load(0, 10, 3, IP, 1, 0, 1, 0);
        chk(res_cap == 2 && wr_idx == 0, "R4 INIT one late", res_cap, 2);
        run_load(0, 10, 3, 0, 0, 0, 1, 0);
        chk(res_cap == 2, "R4 no INIT code", res_cap, 2);
        chk(wr_idx == 0, "R4 no writes", wr_idx, 0);
        chk(t_dv - t_rise == IP, "R4 INIT window", t_dv - t_rise, IP);
        chk(!en_at_dv, "R9 enable low on INIT fail", en_at_dv, 0);

        // R6: DONE on last allowed poll, one late, never
        run_load(0, 77, 4, 0, 1, DP + 1, 1, 0);
        chk(res_cap == 0, "R6 DONE last poll", res_cap, 0);
        run_load(0, 77, 4, 0, 1, DP + 2, 1, 0);
        chk(res_cap == 3, "R6 DONE one late", res_cap, 3);
        run_load(0, 77, 4, 1, 1, 0, 0, 0);
        chk(res_cap == 3 && wr_idx == 4, "R6 no DONE code", res_cap, 3);
        chk(t_dv - t_lw == DP + 2, "R6 DONE window", t_dv - t_lw, DP + 2);
        chk(!en_at_dv, "R9 enable low on DONE fail", en_at_dv, 0);

        // R11: start during a load is ignored
        run_load(0, 200, 9, 3, 1, 2, 1, 1);
        chk(dv_cnt == 1, "R11 no extra result", dv_cnt, 1);
        chk(res_cap == 0 && wr_idx == 9 && !data_bad, "R11 load intact", wr_idx, 9);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule